// File: doc/BRIEF.md
# Link Activity Capture Analyzer

This block watches the signals on a 32-bit link transmit port and copies them into an internal circular FIFO. Software or a debug master reads the FIFO later over a narrow parallel bus. Each stored entry holds the 32-bit data word together with six link control and status lines. When the entry is read, the FIFO's live empty and full flags are added to form a 40-bit view.

Recording runs only while the capture-mode input is high, in one of two ways. In valid-only mode, the block stores the cycles in which the link's active-low write strobe is asserted. In continuous mode, nothing is stored until a start pulse arrives; from that pulse on, every clock cycle is stored. The read bus is 8 or 32 bits wide, fixed at build time. Strobes pick a slice of the oldest entry, and that slice appears on a registered output one cycle later. A separate strobe removes the oldest entry. A build option removes the whole capture logic.

Top module: `link_capture_analyzer`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears the FIFO to empty, stops any continuous run and sets `rd_data` to zero.
- R2: In valid-only mode (`cont_mode` low) with `cap_mode` high, a cycle is stored if and only if `lk_wen_n` is low at that clock edge. Entries are read back in arrival order.
- R3: While `cap_mode` is low, no cycle is stored, whatever the other inputs do.
- R4: In continuous mode (`cont_mode` high) with `cap_mode` high, nothing is stored before `start_evt`. The cycle in which `start_evt` is high and every later cycle are stored, whatever `lk_wen_n` is, until `cap_mode` or `cont_mode` goes low.
- R5: The control-byte read returns bit0 `lk_reset`, bit1 `lk_test`, bit2 `lk_ctrl`, bit3 `lk_wen_n`, bit4 `lk_full`, bit5 `lk_down`, all taken from the oldest entry. Bit6 is the current FIFO-empty flag and bit7 is the current FIFO-full flag. On an empty FIFO, all stored fields read as zero.
- R6: With `BUS_W`=32, `rd_word` returns the 32 data bits of the oldest entry, `rd_ctrl` returns the control byte in bits 7:0 with zeros above, and `rd_byte` has no effect.
- R7: With `BUS_W`=8, `rd_byte[i]` returns data bits 8i+7:8i of the oldest entry, `rd_ctrl` returns the control byte, and `rd_word` has no effect.
- R8: `rd_data` is registered. A strobe that is high at one clock edge updates it at that edge, and `rd_data` holds its value across every edge at which no read strobe is high.
- R9: `rd_advance` high at an edge removes the oldest entry at that edge. On an empty FIFO it is ignored.
- R10: Once `DEPTH` entries are held, further captures are dropped and the full flag stays set until an entry is removed.
- R11: With `ENABLE`=0 no capture logic exists and `rd_data` is always zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cap_mode | input | 1 | Enables capture |
| cont_mode | input | 1 | 1: continuous capture, 0: valid-only capture |
| start_evt | input | 1 | Starts a continuous run |
| lk_data | input | 32 | Link data word |
| lk_reset | input | 1 | Link reset line |
| lk_test | input | 1 | Link test line |
| lk_ctrl | input | 1 | Link control-word line |
| lk_wen_n | input | 1 | Link write strobe, active low |
| lk_full | input | 1 | Link full status |
| lk_down | input | 1 | Link down status |
| rd_byte | input | 4 | Byte read strobes (8-bit bus) |
| rd_word | input | 1 | Data word read strobe (32-bit bus) |
| rd_ctrl | input | 1 | Control byte read strobe |
| rd_advance | input | 1 | Removes the oldest entry |
| rd_data | output | BUS_W | Registered read data |

## Verification
The bench stores a word with `lk_wen_n` high between two valid words. A design that ignores the strobe would return that word in between the others. It pulses the write strobe while `cap_mode` is low, and also holds the strobe low in continuous mode before the start pulse. Either leak would show up as an extra entry before the FIFO reads empty.

It fills past `DEPTH` and then frees one slot. A design that overwrites old entries would lose the first words, and a design with a stuck full flag would refuse the new word. It advances on an empty FIFO and then stores a word. A pointer that slipped past the write pointer would return stale data or a false full.

For the read bus, it drives the strobes that belong to the other bus width and checks that the output holds. It also checks that a strobe takes effect only at the next edge and not in the same cycle.

// File: rtl/link_capture_analyzer.sv
module link_capture_analyzer #(
  parameter int ENABLE = 1,
  parameter int DEPTH  = 16,
  parameter int BUS_W  = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cap_mode,
  input  logic             cont_mode,
  input  logic             start_evt,
  input  logic [31:0]      lk_data,
  input  logic             lk_reset,
  input  logic             lk_test,
  input  logic             lk_ctrl,
  input  logic             lk_wen_n,
  input  logic             lk_full,
  input  logic             lk_down,
  input  logic [3:0]       rd_byte,
  input  logic             rd_word,
  input  logic             rd_ctrl,
  input  logic             rd_advance,
  output logic [BUS_W-1:0] rd_data
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int EW = 38;

  logic [AW:0] wptr, rptr;
  logic        empty, full;

  generate
    if (ENABLE != 0) begin : g_on
      logic [EW-1:0] mem [DEPTH];
      logic [EW-1:0] head;
      logic [7:0]    ctrl_byte;
      logic          running, wr_req, wr_ok, adv_ok;

      assign empty  = (wptr == rptr);
      assign full   = (wptr[AW] != rptr[AW]) && (wptr[AW-1:0] == rptr[AW-1:0]);
      assign wr_req = cap_mode & (cont_mode ? (start_evt | running) : ~lk_wen_n);
      assign wr_ok  = wr_req & ~full;
      assign adv_ok = rd_advance & ~empty;

      always_ff @(posedge clk) begin
        if (rst) begin
          wptr    <= '0;
          rptr    <= '0;
          running <= 1'b0;
        end else begin
          running <= cap_mode & cont_mode & (running | start_evt);
          if (wr_ok)  wptr <= wptr + 1'b1;
          if (adv_ok) rptr <= rptr + 1'b1;
        end
      end

      always_ff @(posedge clk)
        if (wr_ok)
          mem[wptr[AW-1:0]] <= {lk_down, lk_full, lk_wen_n, lk_ctrl, lk_test, lk_reset, lk_data};

      assign head      = empty ? '0 : mem[rptr[AW-1:0]];
      assign ctrl_byte = {full, empty, head[37:32]};

      if (BUS_W == 8) begin : g_b8
        always_ff @(posedge clk) begin
          if (rst)
            rd_data <= '0;
          else if ((|rd_byte) | rd_ctrl)
            rd_data <= (rd_byte[0] ? head[7:0]   : 8'h00) |
                       (rd_byte[1] ? head[15:8]  : 8'h00) |
                       (rd_byte[2] ? head[23:16] : 8'h00) |
                       (rd_byte[3] ? head[31:24] : 8'h00) |
                       (rd_ctrl    ? ctrl_byte   : 8'h00);
        end
      end else begin : g_b32
        always_ff @(posedge clk) begin
          if (rst)
            rd_data <= '0;
          else if (rd_word | rd_ctrl)
            rd_data <= (rd_word ? head[31:0] : 32'h0) |
                       (rd_ctrl ? {24'h0, ctrl_byte} : 32'h0);
        end
      end
    end else begin : g_off
      assign wptr    = '0;
      assign rptr    = '0;
      assign empty   = 1'b1;
      assign full    = 1'b0;
      assign rd_data = '0;
    end
  endgenerate
endmodule

module link_capture_analyzer_chk #(
  parameter int AW    = 4,
  parameter int BUS_W = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             cap_mode,
  input logic             rd_advance,
  input logic [3:0]       rd_byte,
  input logic             rd_word,
  input logic             rd_ctrl,
  input logic [BUS_W-1:0] rd_data,
  input logic [AW:0]      wptr,
  input logic [AW:0]      rptr,
  input logic             empty,
  input logic             full
);
  AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst) !(empty && full)); // R10
  AST_FULL_STICKY: assert property (@(posedge clk) disable iff (rst) (full && !rd_advance) |=> full); // R10
  AST_EMPTY_ADV_IGNORED: assert property (@(posedge clk) disable iff (rst) (empty && rd_advance) |=> $stable(rptr)); // R9
  AST_ADV_ONE_STEP: assert property (@(posedge clk) disable iff (rst) (rd_advance && !empty) |=> rptr == (AW+1)'($past(rptr) + 1'b1)); // R9
  AST_NO_CAPTURE_IDLE: assert property (@(posedge clk) disable iff (rst) !cap_mode |=> $stable(wptr)); // R3
  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst) (!(|rd_byte) && !rd_word && !rd_ctrl) |=> $stable(rd_data)); // R8
endmodule

bind link_capture_analyzer link_capture_analyzer_chk #(.AW(AW), .BUS_W(BUS_W)) u_chk (
  .clk(clk), .rst(rst), .cap_mode(cap_mode), .rd_advance(rd_advance),
  .rd_byte(rd_byte), .rd_word(rd_word), .rd_ctrl(rd_ctrl), .rd_data(rd_data),
  .wptr(wptr), .rptr(rptr), .empty(empty), .full(full)
);

// File: tb/link_capture_analyzer_bench.sv
`timescale 1ns/1ps
module link_capture_analyzer_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cap_mode = 0, cont_mode = 0, start_evt = 0;
  logic [31:0] lk_data = '0;
  logic lk_reset = 0, lk_test = 0, lk_ctrl = 0, lk_wen_n = 1, lk_full = 0, lk_down = 0;
  logic [3:0] rd_byte = '0;
  logic rd_word = 0, rd_ctrl = 0, rd_advance = 0;
  logic [31:0] d32;
  logic [7:0]  d8, doff;
  int checks = 0, fails = 0;

  always #2.5 clk = ~clk;

  link_capture_analyzer #(.ENABLE(1), .DEPTH(8), .BUS_W(32)) u_link_capture_analyzer (
    .clk, .rst, .cap_mode, .cont_mode, .start_evt, .lk_data, .lk_reset, .lk_test, .lk_ctrl,
    .lk_wen_n, .lk_full, .lk_down, .rd_byte, .rd_word, .rd_ctrl, .rd_advance, .rd_data(d32));
  link_capture_analyzer #(.ENABLE(1), .DEPTH(8), .BUS_W(8)) u_b8 (
    .clk, .rst, .cap_mode, .cont_mode, .start_evt, .lk_data, .lk_reset, .lk_test, .lk_ctrl,
    .lk_wen_n, .lk_full, .lk_down, .rd_byte, .rd_word, .rd_ctrl, .rd_advance, .rd_data(d8));
  link_capture_analyzer #(.ENABLE(0), .DEPTH(8), .BUS_W(8)) u_off (
    .clk, .rst, .cap_mode, .cont_mode, .start_evt, .lk_data, .lk_reset, .lk_test, .lk_ctrl,
    .lk_wen_n, .lk_full, .lk_down, .rd_byte, .rd_word, .rd_ctrl, .rd_advance, .rd_data(doff));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  task automatic push(input logic [31:0] d, input logic [2:0] rtc, input logic wn, input logic [1:0] dn_fl);
    @(negedge clk);
    lk_data = d; {lk_ctrl, lk_test, lk_reset} = rtc; lk_wen_n = wn; {lk_down, lk_full} = dn_fl;
  endtask

  task automatic idle();
    @(negedge clk);
    lk_wen_n = 1; start_evt = 0; lk_data = '0; {lk_ctrl, lk_test, lk_reset, lk_down, lk_full} = '0;
  endtask

  task automatic rd(input logic [3:0] by, input logic w, input logic c);
    @(negedge clk); rd_byte = by; rd_word = w; rd_ctrl = c;
    @(negedge clk); rd_byte = '0; rd_word = 0; rd_ctrl = 0;
  endtask

  task automatic adv();
    @(negedge clk); rd_advance = 1;
    @(negedge clk); rd_advance = 0;
  endtask

  task automatic t_reset();
    repeat (4) @(negedge clk);
    rst = 0;
    chk("R1 d32 after reset", d32, 0);
    chk("R1 d8 after reset", {24'h0, d8}, 0);
    rd(4'h0, 0, 1);
    chk("R1 empty flag 32", d32, 32'h40);
    chk("R5 empty flag 8", {24'h0, d8}, 32'h40);
  endtask

  task automatic t_valid();
    cont_mode = 0; cap_mode = 1;
    push(32'hA1B2C3D4, 3'b101, 0, 2'b01);
    push(32'h11111111, 3'b000, 1, 2'b00);
    push(32'hCAFEF00D, 3'b010, 0, 2'b10);
    @(negedge clk); cap_mode = 0; lk_wen_n = 0; lk_data = 32'hDEAD0001;
    idle();
    @(negedge clk); rd_word = 1;
    #1 chk("R8 no same-cycle update", d32, 32'h40);
    @(negedge clk); rd_word = 0;
    chk("R2 R6 first word", d32, 32'hA1B2C3D4);
    repeat (2) @(negedge clk);
    chk("R8 holds without strobe", d32, 32'hA1B2C3D4);
    rd(4'h0, 0, 1);
    chk("R5 ctrl byte 32", d32, 32'h15);
    chk("R5 ctrl byte 8", {24'h0, d8}, 32'h15);
    for (int i = 0; i < 4; i++) begin
      rd(4'(1 << i), 0, 0);
      chk("R7 byte select", {24'h0, d8}, (32'hA1B2C3D4 >> (8 * i)) & 32'hFF);
    end
    chk("R6 byte strobes ignored", d32, 32'h15);
    rd(4'h0, 1, 0);
    chk("R7 word strobe ignored", {24'h0, d8}, 32'hA1);
    adv();
    rd(4'h0, 1, 0);
    chk("R2 R9 skipped word and next entry", d32, 32'hCAFEF00D);
    rd(4'h0, 0, 1);
    chk("R5 ctrl second entry", d32, 32'h22);
    adv();
    rd(4'h0, 0, 1);
    chk("R3 nothing stored while idle", d32, 32'h40);
    rd(4'h0, 1, 0);
    chk("R5 empty reads zero", d32, 0);
    adv();
    cap_mode = 1;
    push(32'h0000BEEF, 3'b000, 0, 2'b00);
    @(negedge clk); cap_mode = 0; lk_wen_n = 1;
    rd(4'h0, 1, 0);
    chk("R9 empty advance ignored", d32, 32'h0000BEEF);
    adv();
    chk("R11 disabled output", {24'h0, doff}, 0);
  endtask

  task automatic t_cont();
    cont_mode = 1; cap_mode = 1;
    for (int i = 0; i < 3; i++) push(32'h77, 3'b000, 0, 2'b00);
    @(negedge clk); start_evt = 1; lk_wen_n = 1; lk_data = 32'd100;
    @(negedge clk); start_evt = 0; lk_data = 32'd101;
    @(negedge clk); lk_data = 32'd102;
    @(negedge clk); cap_mode = 0; lk_data = 32'd103;
    @(negedge clk); cont_mode = 0;
    idle();
    rd(4'h0, 1, 0);
    chk("R4 start cycle stored", d32, 32'd100);
    rd(4'h0, 0, 1);
    chk("R4 wen ignored in continuous", d32, 32'h08);
    adv(); rd(4'h0, 1, 0);
    chk("R4 every cycle stored", d32, 32'd101);
    adv(); rd(4'h0, 1, 0);
    chk("R4 every cycle stored", d32, 32'd102);
    adv(); rd(4'h0, 0, 1);
    chk("R4 run ends with capture mode", d32, 32'h40);
  endtask

  task automatic t_full();
    cont_mode = 0; cap_mode = 1;
    for (int i = 0; i < 10; i++) push(32'h100 + i, 3'b000, 0, 2'b00);
    @(negedge clk); cap_mode = 0; lk_wen_n = 1;
    rd(4'h0, 0, 1);
    chk("R10 full flag", d32, 32'h80);
    rd(4'h0, 1, 0);
    chk("R10 oldest kept", d32, 32'h100);
    adv();
    rd(4'h0, 0, 1);
    chk("R10 full cleared after read", d32, 32'h00);
    cap_mode = 1;
    push(32'h555, 3'b000, 0, 2'b00);
    @(negedge clk); cap_mode = 0; lk_wen_n = 1;
    for (int i = 1; i < 8; i++) begin
      rd(4'h0, 1, 0);
      chk("R10 order after full", d32, 32'h100 + i);
      adv();
    end
    rd(4'h0, 1, 0);
    chk("R10 overflow dropped, new word kept", d32, 32'h555);
    adv();
    rd(4'h0, 0, 1);
    chk("R10 drained", d32, 32'h40);
    chk("R11 disabled output", {24'h0, doff}, 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    t_reset();
    t_valid();
    t_cont();
    t_full();
    summary();
  end
endmodule